// File: doc/BRIEF.md
# Serial Voice-Slot Output Port

This block drives the transmit pin of one telephony transcoder channel. At every frame start it decides which word goes onto the line, and it shifts that word out serially, most significant bit first. The block runs on the bit clock. A frame sync, sampled high on a rising bit-clock edge, opens a slot. The pin is modelled as a data bit plus an output enable. The enable is high only for the bits of the current word, so the pin is high-impedance between slots.

There are three kinds of slot. In normal operation the slot is 4 bits wide and carries the compressed code produced by the transcoder. With the through bit set, the slot is 8 bits wide and carries a PCM word from the input side, which skips the transcoder. With the data-through bit set, a raw 4-bit input code is forwarded unchanged. A source-select bit picks which of two input paths supplies the raw code and the PCM word. Data-through has priority over through, and it also overrides mute. The mode bits and the words are captured when the frame sync arrives, so a change made during a slot only takes effect at the next frame.

Top module: `vslot_port`

## Requirements
- R1: When rst, pdn or init_mode is high at a rising edge, sdo_oe and sdo are 0 after that edge. A frame sync seen during that time starts no slot.
- R2: With dthru_en=0 and thru_en=0 at the frame sync, the slot is 4 bits wide and carries tc_code. Bit 3 appears first, in the cycle after the sync edge.
- R3: With dthru_en=0 and thru_en=1, the slot is 8 bits wide and carries the selected 8-bit PCM word, bit 7 first.
- R4: With dthru_en=1, the slot is 4 bits wide and carries the selected raw 4-bit code unchanged, bit 3 first.
- R5: dthru_en=1 takes precedence over thru_en=1: the slot stays 4 bits wide and mute has no effect.
- R6: src_sel=0 selects lin_a and raw_a; src_sel=1 selects lin_b and raw_b.
- R7: With mute=1 and dthru_en=0, every transmitted bit of the slot is 0, in both the 4-bit and the 8-bit slot.
- R8: Mode bits and data words are captured on the sync edge. Changing them during the slot does not alter the word being sent.
- R9: A frame sync that arrives during a slot restarts output from the MSB of the newly captured word.
- R10: sdo_oe is low in every cycle outside the slot's bits, and sdo is 0 whenever sdo_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pdn | input | 1 | Power-down, holds the pin high-impedance |
| init_mode | input | 1 | Initial mode, holds the pin high-impedance |
| fsync | input | 1 | Frame sync, marks the slot start |
| src_sel | input | 1 | Input path select: 0 = A, 1 = B |
| thru_en | input | 1 | Send the 8-bit PCM word, bypassing the transcoder |
| dthru_en | input | 1 | Send the raw 4-bit input code unchanged |
| mute | input | 1 | Force the slot to zeros (ignored under data-through) |
| tc_code | input | CODE_W | Compressed code from the transcoder |
| lin_a | input | PCM_W | PCM word, input path A |
| lin_b | input | PCM_W | PCM word, input path B |
| raw_a | input | CODE_W | Raw code, input path A |
| raw_b | input | CODE_W | Raw code, input path B |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Output enable; low means high-impedance |

## Verification
Some properties are checked on every cycle. The enable must go low during hold. Data must be zero whenever the pin is undriven. The length of each enable run must match the slot kind chosen at the sync edge, including when a slot is restarted. The first bit after a sync must follow the active mode, mute and source select. The bench scenarios cover the rest: the complete bit order of each word across a sweep of every mode combination, that changes made during a slot have no effect, a mid-slot restart, and power-down arriving part way through a slot.

// File: rtl/vslot_pkg.sv
package vslot_pkg;
  // Slot kind chosen at the frame sync
  typedef enum logic [1:0] {
    SLOT_CODE = 2'd0,
    SLOT_LIN  = 2'd1,
    SLOT_RAW  = 2'd2
  } slot_kind_t;
endpackage

// File: rtl/vslot_sel.sv
module vslot_sel
  import vslot_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int PCM_W  = 8,
  localparam int LW    = $clog2(PCM_W + 1)
) (
  input  logic              dthru_en,
  input  logic              thru_en,
  input  logic              mute,
  input  logic              src_sel,
  input  logic [CODE_W-1:0] tc_code,
  input  logic [PCM_W-1:0]  lin_a,
  input  logic [PCM_W-1:0]  lin_b,
  input  logic [CODE_W-1:0] raw_a,
  input  logic [CODE_W-1:0] raw_b,
  output logic [PCM_W-1:0]  word_al,
  output logic [LW-1:0]     word_len,
  output slot_kind_t        kind
);
  localparam int PAD = PCM_W - CODE_W;

  logic [CODE_W-1:0] raw_pick;
  logic [PCM_W-1:0]  lin_pick;

  assign raw_pick = src_sel ? raw_b : raw_a;
  assign lin_pick = src_sel ? lin_b : lin_a;

  // fixed priority: data-through, then through, then transcoder code
  always_comb begin
    if (dthru_en)     kind = SLOT_RAW;
    else if (thru_en) kind = SLOT_LIN;
    else              kind = SLOT_CODE;
  end

  // words are left aligned so the shifter always starts at its top bit
  always_comb begin
    unique case (kind)
      SLOT_RAW: begin
        word_al  = {raw_pick, {PAD{1'b0}}};
        word_len = LW'(CODE_W);
      end
      SLOT_LIN: begin
        word_al  = mute ? '0 : lin_pick;
        word_len = LW'(PCM_W);
      end
      default: begin
        word_al  = mute ? '0 : {tc_code, {PAD{1'b0}}};
        word_len = LW'(CODE_W);
      end
    endcase
  end
endmodule

// File: rtl/vslot_shift.sv
module vslot_shift #(
  parameter int W  = 8,
  localparam int LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          load,
  input  logic [W-1:0]  word_al,
  input  logic [LW-1:0] word_len,
  output logic          sdo,
  output logic          sdo_oe
);
  logic [W-1:0]  sh_q;
  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      sh_q   <= '0;
      left_q <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (load) begin
      sdo    <= word_al[W-1];
      sh_q   <= {word_al[W-2:0], 1'b0};
      left_q <= word_len - 1'b1;
      sdo_oe <= 1'b1;
    end else if (left_q != '0) begin
      sdo    <= sh_q[W-1];
      sh_q   <= {sh_q[W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end else begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/vslot_port.sv
module vslot_port
  import vslot_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int PCM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdn,
  input  logic              init_mode,
  input  logic              fsync,
  input  logic              src_sel,
  input  logic              thru_en,
  input  logic              dthru_en,
  input  logic              mute,
  input  logic [CODE_W-1:0] tc_code,
  input  logic [PCM_W-1:0]  lin_a,
  input  logic [PCM_W-1:0]  lin_b,
  input  logic [CODE_W-1:0] raw_a,
  input  logic [CODE_W-1:0] raw_b,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int LW = $clog2(PCM_W + 1);

  logic             hold;
  logic             load;
  logic [PCM_W-1:0] word_al;
  logic [LW-1:0]    word_len;
  slot_kind_t       kind;

  assign hold = pdn | init_mode;
  assign load = fsync & ~hold;

  vslot_sel #(.CODE_W(CODE_W), .PCM_W(PCM_W)) i_sel (
    .dthru_en (dthru_en),
    .thru_en  (thru_en),
    .mute     (mute),
    .src_sel  (src_sel),
    .tc_code  (tc_code),
    .lin_a    (lin_a),
    .lin_b    (lin_b),
    .raw_a    (raw_a),
    .raw_b    (raw_b),
    .word_al  (word_al),
    .word_len (word_len),
    .kind     (kind)
  );

  vslot_shift #(.W(PCM_W)) i_shift (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold),
    .load     (load),
    .word_al  (word_al),
    .word_len (word_len),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );
endmodule

// File: rtl/vslot_chk.sv
module vslot_chk #(
  parameter int CODE_W = 4,
  parameter int PCM_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pdn,
  input logic              init_mode,
  input logic              fsync,
  input logic              src_sel,
  input logic              thru_en,
  input logic              dthru_en,
  input logic              mute,
  input logic [PCM_W-1:0]  lin_a,
  input logic [PCM_W-1:0]  lin_b,
  input logic [CODE_W-1:0] raw_a,
  input logic [CODE_W-1:0] raw_b,
  input logic              sdo,
  input logic              sdo_oe
);
  localparam int LW = $clog2(PCM_W + 1);

  logic [LW-1:0] run_q;
  logic [LW-1:0] span_q;
  logic          quiet;

  assign quiet = pdn | init_mode;

  // independent slot-length model: position within the current slot
  always_ff @(posedge clk) begin
    if (rst || quiet) begin
      run_q  <= '0;
      span_q <= '0;
    end else if (fsync) begin
      run_q  <= LW'(1);
      span_q <= (!dthru_en && thru_en) ? LW'(PCM_W) : LW'(CODE_W);
    end else if (run_q != '0 && run_q < span_q) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  // R1
  hold_quiet_chk: assert property (@(posedge clk)
    (rst || pdn || init_mode) |=> (!sdo_oe && !sdo));

  // R10
  undriven_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo);

  // R2
  slot_len_chk: assert property (@(posedge clk) disable iff (rst)
    sdo_oe == (run_q != '0));

  // R7
  mute_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (fsync && !quiet && !dthru_en && mute) |=> (sdo_oe && !sdo));

  // R5
  raw_first_chk: assert property (@(posedge clk) disable iff (rst)
    (fsync && !quiet && dthru_en) |=>
      (sdo_oe && sdo == $past(src_sel ? raw_b[CODE_W-1] : raw_a[CODE_W-1])));

  // R3
  lin_first_chk: assert property (@(posedge clk) disable iff (rst)
    (fsync && !quiet && !dthru_en && thru_en && !mute) |=>
      (sdo_oe && sdo == $past(src_sel ? lin_b[PCM_W-1] : lin_a[PCM_W-1])));
endmodule

bind vslot_port vslot_chk #(.CODE_W(CODE_W), .PCM_W(PCM_W)) i_vslot_chk (
  .clk       (clk),
  .rst       (rst),
  .pdn       (pdn),
  .init_mode (init_mode),
  .fsync     (fsync),
  .src_sel   (src_sel),
  .thru_en   (thru_en),
  .dthru_en  (dthru_en),
  .mute      (mute),
  .lin_a     (lin_a),
  .lin_b     (lin_b),
  .raw_a     (raw_a),
  .raw_b     (raw_b),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe)
);

// File: tb/test_vslot_port.sv
module test_vslot_port;
  localparam int CW = 4;
  localparam int PW = 8;
  localparam int NS = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pdn = 1'b0;
  logic          init_mode = 1'b0;
  logic          fsync = 1'b0;
  logic          src_sel = 1'b0;
  logic          thru_en = 1'b0;
  logic          dthru_en = 1'b0;
  logic          mute = 1'b0;
  logic [CW-1:0] tc_code = '0;
  logic [PW-1:0] lin_a = '0;
  logic [PW-1:0] lin_b = '0;
  logic [CW-1:0] raw_a = '0;
  logic [CW-1:0] raw_b = '0;
  logic          sdo;
  logic          sdo_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  vslot_port #(.CODE_W(CW), .PCM_W(PW)) i_vslot_port (
    .clk(clk), .rst(rst), .pdn(pdn), .init_mode(init_mode), .fsync(fsync),
    .src_sel(src_sel), .thru_en(thru_en), .dthru_en(dthru_en), .mute(mute),
    .tc_code(tc_code), .lin_a(lin_a), .lin_b(lin_b), .raw_a(raw_a),
    .raw_b(raw_b), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected pin pattern for a slot, packed {oe[NS-1:0], data[NS-1:0]}, sample k at bit k
  function automatic logic [31:0] expect_slot(input logic d, t, m, s,
      input logic [CW-1:0] code, input logic [PW-1:0] pa, pb,
      input logic [CW-1:0] ra, rb, input int first);
    logic [PW-1:0] w;
    int len;
    logic [NS-1:0] eo, ed;
    if (d) begin len = CW; w = {4'b0, (s ? rb : ra)}; end
    else if (t) begin len = PW; w = m ? '0 : (s ? pb : pa); end
    else begin len = CW; w = m ? '0 : {4'b0, code}; end
    eo = '0; ed = '0;
    for (int k = first; k < NS; k++) begin
      if (k - first < len) begin
        eo[k] = 1'b1;
        ed[k] = w[len - 1 - (k - first)];
      end
    end
    return {12'b0, eo, ed};
  endfunction

  task automatic set_cfg(input logic d, t, m, s, input logic [CW-1:0] code,
      input logic [PW-1:0] pa, pb, input logic [CW-1:0] ra, rb);
    dthru_en = d; thru_en = t; mute = m; src_sel = s;
    tc_code = code; lin_a = pa; lin_b = pb; raw_a = ra; raw_b = rb;
  endtask

  task automatic run_slot(input logic d, t, m, s, input logic [CW-1:0] code,
      input logic [PW-1:0] pa, pb, input logic [CW-1:0] ra, rb,
      input logic scramble);
    logic [NS-1:0] oo, od;
    string req;
    @(negedge clk);
    set_cfg(d, t, m, s, code, pa, pb, ra, rb);
    fsync = 1'b1;
    for (int k = 0; k < NS; k++) begin
      @(negedge clk);
      oo[k] = sdo_oe; od[k] = sdo;
      if (k == 0) begin
        fsync = 1'b0;
        // R8: disturb every capture input while the slot is running
        if (scramble) set_cfg(~d, ~t, ~m, ~s, ~code, ~pa, ~pb, ~ra, ~rb);
      end
    end
    if (d)      req = "R4 R5 R6 R10 R8";
    else if (t) req = "R3 R6 R7 R10 R8";
    else        req = "R2 R7 R10 R8";
    check(req, {12'b0, oo, od}, expect_slot(d, t, m, s, code, pa, pb, ra, rb, 0));
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [NS-1:0] oo, od;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {30'b0, sdo_oe, sdo}, 32'd0);
    rst = 1'b0;

    // sweep every mode combination with 16 data patterns
    for (int c = 0; c < 16; c++) begin
      for (int v = 0; v < 16; v++) begin
        run_slot(c[3], c[2], c[1], c[0], CW'(v), PW'(v * 13 + 7),
                 ~PW'(v * 29), CW'(v) ^ 4'h5, ~CW'(v), v[0]);
      end
    end

    // R1: initial mode blocks a frame sync
    @(negedge clk);
    init_mode = 1'b1;
    set_cfg(0, 1, 0, 0, 4'hF, 8'hFF, 8'hFF, 4'hF, 4'hF);
    fsync = 1'b1;
    for (int k = 0; k < NS; k++) begin
      @(negedge clk); oo[k] = sdo_oe; od[k] = sdo;
      if (k == 0) fsync = 1'b0;
    end
    check("R1 init_mode", {12'b0, oo, od}, 32'd0);
    init_mode = 1'b0;

    // R1: power-down part way through an 8-bit slot
    @(negedge clk);
    set_cfg(0, 1, 0, 1, 4'h0, 8'h00, 8'hFF, 4'h0, 4'h0);
    fsync = 1'b1;
    for (int k = 0; k < NS; k++) begin
      @(negedge clk); oo[k] = sdo_oe; od[k] = sdo;
      if (k == 0) fsync = 1'b0;
      if (k == 2) pdn = 1'b1;
    end
    check("R1 pdn mid-slot", {12'b0, oo, od}, {12'b0, 10'h007, 10'h007});
    pdn = 1'b0;

    // R9: restart an 8-bit slot with a 4-bit code after three bits
    @(negedge clk);
    set_cfg(0, 1, 0, 0, 4'h0, 8'hA5, 8'h00, 4'h0, 4'h0);
    fsync = 1'b1;
    for (int k = 0; k < NS; k++) begin
      @(negedge clk); oo[k] = sdo_oe; od[k] = sdo;
      if (k == 0) fsync = 1'b0;
      if (k == 2) begin
        set_cfg(0, 0, 0, 0, 4'h9, 8'h00, 8'h00, 4'h0, 4'h0);
        fsync = 1'b1;
      end
      if (k == 3) fsync = 1'b0;
    end
    // first three bits 1,0,1 of A5 then 1,0,0,1 of 9, then idle
    check("R9 restart", {12'b0, oo, od}, {12'b0, 10'h07F, 10'h04D});

    // R9: back-to-back syncs, each cycle restarts at the new MSB
    @(negedge clk);
    set_cfg(1, 0, 0, 0, 4'h0, 8'h00, 8'h00, 4'h8, 4'h0);
    fsync = 1'b1;
    @(negedge clk);
    check("R9 first MSB", {30'b0, sdo_oe, sdo}, 32'd3);
    raw_a = 4'h0;
    @(negedge clk);
    fsync = 1'b0;
    check("R9 repeated sync", {30'b0, sdo_oe, sdo}, 32'd2);

    repeat (12) @(negedge clk);
    // R10: idle pin after the slot
    check("R10 idle", {30'b0, sdo_oe, sdo}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule